// File: doc/BRIEF.md
# Interval Timer Bus Register Front End

This block is the processor-facing side of a three-channel interval timer. A two-bit address picks one of three counter ports or the control port. An 8-bit write bus carries control words and count bytes, and an 8-bit read bus returns count bytes. The block decodes each control word into a per-channel counting mode and a byte access type. It joins one or two written bytes into a 16-bit count. When a count is complete, it presents that count with a one-cycle load strobe to the counting logic, which sits outside this block.

The counting logic returns each channel's live value on an input. A latch command takes a snapshot of that value and keeps it until software has read all of it. Reads return bytes of the snapshot, or of the live value when no snapshot is held. The byte order depends on the channel's access type.

Top module: `tmr_bus_regs`

## Requirements
- R1: After reset every channel reports mode 0 and count 0, no load strobe is raised, no snapshot is held, and the channel uses low-then-high access with its write and read byte toggles cleared.
- R2: A write to address 3 is a control word. Bits 7:6 select the channel. Bits 5:4 select the access: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 give the mode. Bit 0 has no effect. A control word with a non-zero access field sets the channel's mode and access, and the new mode appears on the mode output after the next clock edge.
- R3: Mode codes 6 and 7 are reported as modes 2 and 3. The codes 0 to 5 pass through unchanged.
- R4: In low-then-high access, the first write to a counter port stores the low byte and does not strobe. The second write supplies the high byte, and after that edge the count output shows {high, low} with the load strobe high for exactly one cycle.
- R5: In low-only access, one write loads {8'h00, byte}. In high-only access, one write loads {byte, 8'h00}. Each such write strobes the load output.
- R6: A control word for a channel clears that channel's write byte toggle. A half-finished low-then-high write is abandoned, and the next write is taken as a low byte.
- R7: A latch command (access field 00) copies the channel's live value into a snapshot and leaves mode and access unchanged. Further latch commands to that channel are ignored while the snapshot is held.
- R8: In low-then-high access, reads return the low byte first and the high byte second. The snapshot is released after its high byte has been read.
- R9: With no snapshot held, a read returns the selected byte of the live value at the time of the read.
- R10: Completing a count load discards any snapshot held for that channel.
- R11: A control word with channel field 11 changes no mode, strobes nothing and takes no snapshot.
- R12: In low-only or high-only access, one read returns the selected byte and releases the snapshot.
- R13: Only the addressed channel reacts. At most one load strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Port select: 0 to 2 counters, 3 control |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, advances the read sequence |
| rdata | output | 8 | Read data for the addressed counter port (0 at address 3) |
| live_cnt | input | 48 | Live counter values, channel n at bits 16n+15:16n |
| ch_mode | output | 9 | Mode per channel, channel n at bits 3n+2:3n |
| ch_count | output | 48 | Loaded count per channel |
| ch_load | output | 3 | One-cycle count-load strobe per channel |

## Verification
The assertions check the following rules on every cycle:
- the folding of modes 6 and 7 (mode codes 6 and 7 never appear on the mode output);
- the write toggle cleared by a control word;
- the snapshot holding steady until a full read or a load;
- the discard of the snapshot on a load;
- the release after the high byte;
- the one-hot load strobes;
- the inertness of the read-back control word.

Only the directed scenarios show that the bytes carry the right values. They confirm that the count is assembled as {high, low}, that reads come out in the right order, and that reads follow the live value when nothing is held. They also show that the snapshot keeps its old value across a second latch, and that a half-finished write is abandoned.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctl_word_t;

  // modes 6 and 7 fold onto 2 and 3
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [CNT_W-1:0] merge_count(input acc_e a,
                                                   input logic [BYTE_W-1:0] lo,
                                                   input logic [BYTE_W-1:0] nb);
    case (a)
      ACC_LO:  return {{BYTE_W{1'b0}}, nb};
      ACC_HI:  return {nb, {BYTE_W{1'b0}}};
      default: return {nb, lo};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input acc_e a, input logic second,
                                                  input logic [CNT_W-1:0] v);
    case (a)
      ACC_HI:   return v[CNT_W-1:BYTE_W];
      ACC_LOHI: return second ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
      default:  return v[BYTE_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_regs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    ctl_set,
  output logic [NCH-1:0]    latch_req,
  output logic [NCH-1:0]    cnt_wr,
  output logic [NCH-1:0]    cnt_rd,
  output acc_e              new_acc,
  output logic [MODE_W-1:0] new_mode
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  ctl_word_t cw;
  logic      is_ctl;

  assign cw       = ctl_word_t'(wdata);
  assign is_ctl   = wr_en && (addr == CTRL_ADDR);
  assign new_acc  = cw.acc;
  assign new_mode = cw.mode;

  wire unused_bcd = cw.bcd;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit          = is_ctl && (cw.sel == 2'(i));
    assign ctl_set[i]   = hit && (cw.acc != ACC_LATCH);
    assign latch_req[i] = hit && (cw.acc == ACC_LATCH);
    assign cnt_wr[i]    = wr_en && (addr == AW'(i));
    assign cnt_rd[i]    = rd_en && (addr == AW'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_set,
  input  logic              latch_req,
  input  logic              cnt_wr,
  input  logic              cnt_rd,
  input  acc_e              new_acc,
  input  logic [MODE_W-1:0] new_mode,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  count,
  output logic              load,
  output logic [BYTE_W-1:0] rd_byte
);
  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              wtog_q, rtog_q, held_q, load_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  count_q, hold_q;

  // named internal events
  logic load_done, rd_release, latch_take, first_byte;
  logic [CNT_W-1:0] rd_src;

  assign first_byte = cnt_wr && (acc_q == ACC_LOHI) && !wtog_q;
  assign load_done  = cnt_wr && !first_byte;
  assign rd_release = cnt_rd && ((acc_q != ACC_LOHI) || rtog_q);
  assign latch_take = latch_req && !held_q;
  assign rd_src     = held_q ? hold_q : live;
  assign rd_byte    = pick_byte(acc_q, rtog_q, rd_src);

  assign mode  = mode_q;
  assign count = count_q;
  assign load  = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_LOHI;
      mode_q  <= '0;
      wtog_q  <= 1'b0;
      lo_q    <= '0;
      count_q <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= load_done;
      if (ctl_set) begin
        acc_q  <= new_acc;
        mode_q <= fold_mode(new_mode);
        wtog_q <= 1'b0;
      end else if (first_byte) begin
        lo_q   <= wdata;
        wtog_q <= 1'b1;
      end else if (load_done) begin
        count_q <= merge_count(acc_q, lo_q, wdata);
        wtog_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hold_q <= '0;
      rtog_q <= 1'b0;
    end else begin
      if (cnt_rd && (acc_q == ACC_LOHI)) rtog_q <= ~rtog_q;
      if (latch_take) begin
        held_q <= 1'b1;
        hold_q <= live;
        rtog_q <= 1'b0;
      end else if (load_done || rd_release) begin
        held_q <= 1'b0;
      end
    end
  end

  // R3
  mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[2:1] != 2'b11);

  // R6
  ctl_clr_wtog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set |=> !wtog_q);

  // R4
  lohi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_byte && !ctl_set) |=> (wtog_q && !load_q));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rd_release && !load_done) |=> (held_q && $stable(hold_q)));

  // R10
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !held_q);

  // R8
  hi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && held_q && (acc_q == ACC_LOHI) && rtog_q && !latch_req) |=> !held_q);
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
  import tmr_regs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  rd_en,
  output logic [BYTE_W-1:0]     rdata,
  input  logic [NCH*CNT_W-1:0]  live_cnt,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH*CNT_W-1:0]  ch_count,
  output logic [NCH-1:0]        ch_load
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic [NCH-1:0]    ctl_set, latch_req, cnt_wr, cnt_rd;
  acc_e              new_acc;
  logic [MODE_W-1:0] new_mode;
  logic [BYTE_W-1:0] rd_bytes [NCH];

  tmr_ctl_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .ctl_set(ctl_set), .latch_req(latch_req), .cnt_wr(cnt_wr), .cnt_rd(cnt_rd),
    .new_acc(new_acc), .new_mode(new_mode)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctl_set(ctl_set[i]), .latch_req(latch_req[i]),
      .cnt_wr(cnt_wr[i]), .cnt_rd(cnt_rd[i]),
      .new_acc(new_acc), .new_mode(new_mode), .wdata(wdata),
      .live(live_cnt[i*CNT_W +: CNT_W]),
      .mode(ch_mode[i*MODE_W +: MODE_W]),
      .count(ch_count[i*CNT_W +: CNT_W]),
      .load(ch_load[i]),
      .rd_byte(rd_bytes[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(i)) rdata = rd_bytes[i];
  end

  // R13
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  // R11
  rdbk_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == CTRL_ADDR) && (wdata[7:6] == 2'b11))
      |=> ($stable(ch_mode) && (ch_load == '0)));
endmodule

// File: tb/tb_tmr_bus_regs.sv
module tb_tmr_bus_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        wr_en = 0;
  logic [7:0]  wdata = 0;
  logic        rd_en = 0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = 0;
  logic [8:0]  ch_mode;
  logic [47:0] ch_count;
  logic [2:0]  ch_load;

  int total = 0;
  int bad = 0;

  tmr_bus_regs dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ctl(input logic [1:0] sel, input logic [1:0] acc, input logic [2:0] m);
    wr(2'd3, {sel, acc, m, 1'b0});
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [15:0] cnt(input int i); return ch_count[i*16 +: 16]; endfunction
  function automatic logic [2:0] md(input int i); return ch_mode[i*3 +: 3]; endfunction

  task automatic t_reset;
    logic [7:0] b;
    chk("R1 modes", ch_mode, 0);
    chk("R1 counts", ch_count, 0);
    chk("R1 load", ch_load, 0);
    live_cnt[15:0] = 16'h1234;
    rd(0, b); chk("R1 first byte low", b, 8'h34);
    rd(0, b); chk("R1 second byte high", b, 8'h12);
  endtask

  task automatic t_lohi;
    ctl(0, 2'b11, 3'd2);
    chk("R2 mode ch0", md(0), 2);
    wr(0, 8'h78);
    chk("R4 no strobe first byte", ch_load, 0);
    chk("R4 count unchanged", cnt(0), 0);
    wr(0, 8'h56);
    chk("R4 strobe", ch_load, 3'b001);
    chk("R4 count", cnt(0), 16'h5678);
    chk("R13 other count", cnt(1), 0);
    @(negedge clk);
    chk("R4 strobe one cycle", ch_load, 0);
  endtask

  task automatic t_alias;
    ctl(1, 2'b11, 3'd6); chk("R3 6->2", md(1), 2);
    ctl(1, 2'b11, 3'd7); chk("R3 7->3", md(1), 3);
    ctl(1, 2'b11, 3'd5); chk("R3 5 kept", md(1), 5);
    wr(2'd3, {2'b01, 2'b11, 3'd4, 1'b1});
    chk("R2 bcd bit ignored", md(1), 4);
    chk("R13 ch0 mode kept", md(0), 2);
  endtask

  task automatic t_single;
    ctl(2, 2'b01, 3'd0);
    wr(2, 8'hAB);
    chk("R5 low-only count", cnt(2), 16'h00AB);
    chk("R13 only ch2 strobes", ch_load, 3'b100);
    ctl(2, 2'b10, 3'd0);
    wr(2, 8'hCD);
    chk("R5 high-only count", cnt(2), 16'hCD00);
  endtask

  task automatic t_toggle_reset;
    ctl(0, 2'b11, 3'd0);
    wr(0, 8'h11);
    ctl(0, 2'b11, 3'd0);
    wr(0, 8'h22);
    chk("R6 restarted low byte no strobe", ch_load, 0);
    wr(0, 8'h33);
    chk("R6 count after restart", cnt(0), 16'h3322);
  endtask

  task automatic t_latch;
    logic [7:0] b;
    ctl(1, 2'b11, 3'd2);
    live_cnt[31:16] = 16'hBEEF;
    ctl(1, 2'b00, 3'd0);
    chk("R7 latch keeps mode", md(1), 2);
    live_cnt[31:16] = 16'h1234;
    ctl(1, 2'b00, 3'd0);
    rd(1, b); chk("R8 held low first", b, 8'hEF);
    rd(1, b); chk("R7 second latch ignored", b, 8'hBE);
    rd(1, b); chk("R8 released low live", b, 8'h34);
    rd(1, b); chk("R8 released high live", b, 8'h12);
  endtask

  task automatic t_live;
    logic [7:0] b;
    ctl(2, 2'b11, 3'd3);
    live_cnt[47:32] = 16'hA55A;
    rd(2, b); chk("R9 live low", b, 8'h5A);
    live_cnt[47:32] = 16'h0F1E;
    rd(2, b); chk("R9 live high follows", b, 8'h0F);
  endtask

  task automatic t_load_drop;
    logic [7:0] b;
    ctl(0, 2'b11, 3'd0);
    live_cnt[15:0] = 16'h4242;
    ctl(0, 2'b00, 3'd0);
    live_cnt[15:0] = 16'h9988;
    wr(0, 8'h01); wr(0, 8'h02);
    rd(0, b); chk("R10 hold discarded low", b, 8'h88);
    rd(0, b); chk("R10 hold discarded high", b, 8'h99);
  endtask

  task automatic t_readback;
    logic [7:0] b;
    logic [8:0] m0;
    m0 = ch_mode;
    live_cnt[47:32] = 16'h7777;
    wr(2'd3, 8'hF6);
    chk("R11 no mode change", ch_mode, m0);
    chk("R11 no strobe", ch_load, 0);
    wr(2'd3, 8'hC0);
    live_cnt[47:32] = 16'h8899;
    rd(2, b); chk("R11 no snapshot", b, 8'h99);
    rd(2, b);
  endtask

  task automatic t_single_read;
    logic [7:0] b;
    ctl(1, 2'b10, 3'd0);
    live_cnt[31:16] = 16'hC3A5;
    ctl(1, 2'b00, 3'd0);
    live_cnt[31:16] = 16'h0000;
    rd(1, b); chk("R12 held high byte", b, 8'hC3);
    rd(1, b); chk("R12 released after one read", b, 8'h00);
    ctl(1, 2'b01, 3'd0);
    live_cnt[31:16] = 16'h00F1;
    rd(1, b); chk("R12 low-only live", b, 8'hF1);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lohi();
    t_alias();
    t_single();
    t_toggle_reset();
    t_latch();
    t_live();
    t_load_drop();
    t_readback();
    t_single_read();
    finish_run();
  end
endmodule